// File: doc/BRIEF.md
# ATA DMA Burst Writer

This block sits on a sound board between an ATA drive's DMA data port and a 16-bit wave memory. The sound processor loads a 32-bit transfer pointer through two 16-bit register writes. The pointer counts 16-bit words, so the byte address it stands for is twice its value. A burst begins when the drive's DMA request goes from low to high. The block then holds the DMA acknowledge asserted and takes one word from the drive in each cycle that the drive reports ready. It stores that word at the pointer and advances the pointer by one. The burst ends when the request drops. The pointer is never cleared between bursts, so several bursts without a reload fill consecutive memory.

The block also holds the sound processor's interrupt control field. Four pending interrupt levels (1, 2, 4 and 6) are set by their sources. The drive interrupt feeds level 6, and only while the enable bit is set. A control write that clears a bit which was set clears the matching pending level. Only the lowest such falling bit is acted on per write.

Top module: `ata_dma_writer`

## Requirements
- R1: A register write with select 1 replaces pointer bits 15:0 with the write data and keeps bits 31:16. The new value is visible on `xfer_ptr` after the clock edge that takes the write.
- R2: A register write with select 2 replaces pointer bits 31:16 and keeps bits 15:0. Select 3 changes nothing.
- R3: The pointer is a word pointer: each stored word goes to wave address `xfer_ptr[MEM_AW-1:0]`. Increments carry from bit 15 into bit 16, and the wave address wraps at the memory size.
- R4: A burst starts only on a low-to-high change of `dma_req`. A request that is already high when reset ends starts nothing until it has dropped and risen again.
- R5: During a burst `dma_ack` stays high. In each cycle with `dma_req` and `drv_rdy` both high, one word is taken and stored at the pointer, and the pointer then advances by one. Cycles with `drv_rdy` low store nothing and lose nothing.
- R6: One cycle after `dma_req` is seen low during a burst, `dma_ack` is low and no further word is stored.
- R7: The pointer keeps its value between bursts, so a second burst continues where the first one ended.
- R8: Stored words keep their byte order: `wm_wdata` equals `drv_data` exactly.
- R9: A rising `drv_irq` sets pending level 6 (`irq_pend[3]`) only when control bit 10 is set at that edge.
- R10: A control write (select 0) looks at bits 7, 8, 9 and 10, which clear levels 1, 2, 4 and 6 (`irq_pend[0..3]`). Of the bits that were set and are now written 0, only the lowest-numbered one clears its level. Bits rising or staying the same clear nothing, and a clear wins over a set in the same cycle.
- R11: A rising edge on `ext_irq[0]`, `ext_irq[1]` or `ext_irq[2]` sets pending level 1, 2 or 4 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control, 1 pointer low, 2 pointer high, 3 none |
| reg_wdata | input | 16 | Register write data |
| dma_req | input | 1 | Drive DMA request |
| dma_ack | output | 1 | DMA acknowledge to the drive |
| drv_rdy | input | 1 | Drive has a word on `drv_data` this cycle |
| drv_data | input | 16 | Word from the drive |
| drv_irq | input | 1 | Drive interrupt request |
| ext_irq | input | 3 | Sources for levels 1, 2, 4 |
| irq_pend | output | 4 | Pending levels 1, 2, 4, 6 (bit 0 to bit 3) |
| wm_we | output | 1 | Wave memory write enable |
| wm_addr | output | MEM_AW | Wave memory word address |
| wm_wdata | output | 16 | Wave memory write data |
| xfer_ptr | output | 32 | Current transfer pointer |

## Verification
The bench builds the block with `MEM_AW` set to 8. A burst that starts at pointer 0x0001FFFE therefore shows two effects at once: the wave address wraps from 0xFF to 0x00, and the pointer carries from its low half into its high half. Drive-side stalls are produced by a ready pattern that skips every second or third cycle. The interrupt tests combine several falling control bits in one write, so the lowest-first rule can be seen apart from the plain clear.

// File: rtl/ata_dma_pkg.sv
package ata_dma_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_PTR_HI = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic {
    DMA_IDLE  = 1'b0,
    DMA_BURST = 1'b1
  } dma_state_e;

  // first control bit that maps to an interrupt level; levels follow upward
  localparam int CLR_BASE = 7;
  localparam int LVL_N    = 4;
endpackage

// File: rtl/ata_ptr_reg.sv
module ata_ptr_reg #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [HALF_W-1:0]   wdata,
  input  logic                inc,
  output logic [2*HALF_W-1:0] ptr
);
  localparam int PTR_W = 2 * HALF_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld_lo) begin
      ptr <= {ptr[PTR_W-1:HALF_W], wdata};
    end else if (ld_hi) begin
      ptr <= {wdata, ptr[HALF_W-1:0]};
    end else if (inc) begin
      ptr <= ptr + PTR_W'(1);
    end
  end

  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_lo)) |-> ptr[PTR_W-1:HALF_W] == $past(ptr[PTR_W-1:HALF_W])); // R1
  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_hi) && !$past(ld_lo)) |-> ptr[HALF_W-1:0] == $past(ptr[HALF_W-1:0])); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inc) && !$past(ld_lo) && !$past(ld_hi)) |-> ptr == $past(ptr) + PTR_W'(1)); // R5
endmodule

// File: rtl/ata_dma_seq.sv
module ata_dma_seq
  import ata_dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_req,
  input  logic              drv_rdy,
  input  logic [DATA_W-1:0] drv_data,
  input  logic [MEM_AW-1:0] ptr_addr,
  output logic              dma_ack,
  output logic              inc,
  output logic              wm_we,
  output logic [MEM_AW-1:0] wm_addr,
  output logic [DATA_W-1:0] wm_wdata
);
  dma_state_e state_q, state_d;
  logic       req_q;
  logic       req_rise;

  // reset value 1: a request already high at reset exit is not an edge
  assign req_rise = dma_req && !req_q;
  assign inc      = (state_q == DMA_BURST) && dma_req && drv_rdy;
  assign dma_ack  = (state_q == DMA_BURST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DMA_IDLE:  if (req_rise) state_d = DMA_BURST;
      DMA_BURST: if (!dma_req) state_d = DMA_IDLE;
      default:   state_d = DMA_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= DMA_IDLE;
      req_q    <= 1'b1;
      wm_we    <= 1'b0;
      wm_addr  <= '0;
      wm_wdata <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= dma_req;
      wm_we   <= inc;
      if (inc) begin
        wm_addr  <= ptr_addr;
        wm_wdata <= drv_data;
      end
    end
  end

  AST_BURST_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_ack) |-> ($past(dma_req) && !$past(req_q))); // R4
  AST_WRITE_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    wm_we |-> ($past(dma_ack) && $past(dma_req) && $past(drv_rdy))); // R5
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && !dma_req) |=> (!dma_ack && !inc)); // R6
endmodule

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl #(
  parameter int LVL_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [LVL_N-1:0] ctl_field,
  input  logic [LVL_N-2:0] ext_src,
  input  logic             drv_irq,
  output logic [LVL_N-1:0] irq_pend
);
  logic [LVL_N-1:0] ctl_q;
  logic [LVL_N-1:0] src_q, src_now, src_en, rise, fall, clr;

  assign src_now = {drv_irq, ext_src};
  // the top level is the drive interrupt, gated by its own control bit
  assign src_en  = {ctl_q[LVL_N-1], {(LVL_N-1){1'b1}}};
  assign rise    = src_now & ~src_q & src_en;
  assign fall    = ctl_we ? (ctl_q & ~ctl_field) : '0;

  for (genvar i = 0; i < LVL_N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign clr[i] = fall[i];
    end else begin : g_rest
      assign clr[i] = fall[i] && !(|fall[i-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      src_q    <= '0;
      irq_pend <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_field;
      src_q    <= src_now;
      irq_pend <= (irq_pend | rise) & ~clr;
    end
  end

  AST_TOP_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pend[LVL_N-1]) |-> $past(ctl_q[LVL_N-1])); // R9
  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $countones($past(irq_pend) & ~irq_pend) <= 1); // R10
  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (($past(irq_pend) & ~irq_pend) != '0) |-> $past(ctl_we)); // R10
endmodule

// File: rtl/ata_dma_writer.sv
module ata_dma_writer
  import ata_dma_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [1:0]          reg_sel,
  input  logic [HALF_W-1:0]   reg_wdata,
  input  logic                dma_req,
  output logic                dma_ack,
  input  logic                drv_rdy,
  input  logic [DATA_W-1:0]   drv_data,
  input  logic                drv_irq,
  input  logic [LVL_N-2:0]    ext_irq,
  output logic [LVL_N-1:0]    irq_pend,
  output logic                wm_we,
  output logic [MEM_AW-1:0]   wm_addr,
  output logic [DATA_W-1:0]   wm_wdata,
  output logic [2*HALF_W-1:0] xfer_ptr
);
  localparam int PTR_W = 2 * HALF_W;

  reg_sel_e sel;
  logic     ld_lo, ld_hi, ctl_we, inc;

  assign sel    = reg_sel_e'(reg_sel);
  assign ld_lo  = reg_we && (sel == SEL_PTR_LO);
  assign ld_hi  = reg_we && (sel == SEL_PTR_HI);
  assign ctl_we = reg_we && (sel == SEL_CTRL);

  ata_ptr_reg #(.HALF_W(HALF_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .wdata (reg_wdata),
    .inc   (inc),
    .ptr   (xfer_ptr)
  );

  ata_dma_seq #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .dma_req  (dma_req),
    .drv_rdy  (drv_rdy),
    .drv_data (drv_data),
    .ptr_addr (xfer_ptr[MEM_AW-1:0]),
    .dma_ack  (dma_ack),
    .inc      (inc),
    .wm_we    (wm_we),
    .wm_addr  (wm_addr),
    .wm_wdata (wm_wdata)
  );

  ata_irq_ctl #(.LVL_N(LVL_N)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_field (reg_wdata[CLR_BASE +: LVL_N]),
    .ext_src   (ext_irq),
    .drv_irq   (drv_irq),
    .irq_pend  (irq_pend)
  );

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!dma_ack) |=> !wm_we); // R5
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    (PTR_W == 32) |-> (MEM_AW <= PTR_W)); // R3
endmodule

// File: tb/tb_ata_dma_writer.sv
module tb_ata_dma_writer;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 8;

  logic        clk, rst, reg_we, dma_req, dma_ack, drv_rdy, drv_irq, wm_we;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata, drv_data, wm_wdata;
  logic [2:0]  ext_irq;
  logic [3:0]  irq_pend;
  logic [MEM_AW-1:0] wm_addr;
  logic [31:0] xfer_ptr;

  ata_dma_writer #(.MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dma_req(dma_req), .dma_ack(dma_ack), .drv_rdy(drv_rdy), .drv_data(drv_data),
    .drv_irq(drv_irq), .ext_irq(ext_irq), .irq_pend(irq_pend), .wm_we(wm_we),
    .wm_addr(wm_addr), .wm_wdata(wm_wdata), .xfer_ptr(xfer_ptr)
  );

  typedef struct packed { logic [MEM_AW-1:0] a; logic [15:0] d; } item_t;
  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_ptr = '0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each wave-memory write
  always @(negedge clk) begin
    if (!rst && wm_we) begin
      if (exp_q.size() == 0) begin
        check_eq("R4/R6 write outside a burst", 64'(wm_we), 64'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check_eq("R3 wave address", 64'(wm_addr), 64'(it.a));
        check_eq("R8 stored word", 64'(wm_wdata), 64'(it.d));
      end
    end
  end

  function automatic logic [15:0] word_at(input logic [31:0] p);
    return {p[7:0] ^ 8'h3C, p[7:0] ^ 8'hC5};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel == 2'd1) exp_ptr[15:0]  = data;
    if (sel == 2'd2) exp_ptr[31:16] = data;
  endtask

  task automatic burst(input int n, input int stall_every);
    int got = 0;
    int k = 0;
    bit stall;
    @(negedge clk);
    dma_req = 1'b1; drv_rdy = 1'b0;
    @(posedge clk);
    while (got < n) begin
      @(negedge clk);
      check_eq("R5 ack held in burst", 64'(dma_ack), 64'd1);
      stall = (stall_every > 0) && ((k % stall_every) == stall_every - 1);
      drv_rdy  = !stall;
      drv_data = stall ? 16'hDEAD : word_at(exp_ptr);
      @(posedge clk);
      if (!stall) begin
        exp_q.push_back('{a: exp_ptr[MEM_AW-1:0], d: word_at(exp_ptr)});
        exp_ptr = exp_ptr + 1;
        got++;
      end
      k++;
    end
    @(negedge clk);
    dma_req = 1'b0; drv_rdy = 1'b0;
    @(negedge clk);
    check_eq("R6 ack released", 64'(dma_ack), 64'd0);
    check_eq("R7 pointer after burst", 64'(xfer_ptr), 64'(exp_ptr));
  endtask

  task automatic pulse_drv();
    @(negedge clk); drv_irq = 1'b1;
    @(negedge clk); drv_irq = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    dma_req = 1'b1; drv_rdy = 1'b1; drv_data = 16'h1234; drv_irq = 1'b0; ext_irq = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("reset irq_pend", 64'(irq_pend), 64'd0);
    check_eq("reset pointer", 64'(xfer_ptr), 64'd0);
    check_eq("reset wm_we", 64'(wm_we), 64'd0);
    repeat (4) @(negedge clk);
    check_eq("R4 request high at reset exit starts nothing", 64'(dma_ack), 64'd0);
    dma_req = 1'b0; drv_rdy = 1'b0;

    wr(2'd1, 16'h0010);
    check_eq("R1 low load", 64'(xfer_ptr), 64'h0000_0010);
    wr(2'd2, 16'h0003);
    check_eq("R2 high load", 64'(xfer_ptr), 64'h0003_0010);
    wr(2'd1, 16'h0020);
    check_eq("R1 low load keeps high half", 64'(xfer_ptr), 64'h0003_0020);
    wr(2'd3, 16'hFFFF);
    check_eq("R2 select 3 ignored", 64'(xfer_ptr), 64'h0003_0020);

    burst(5, 0);                       // R5 plain burst
    burst(3, 0);                       // R7 continues
    burst(6, 2);                       // R5 with stalls
    check_eq("R7 pointer after three bursts", 64'(xfer_ptr), 64'h0003_002E);
    wr(2'd2, 16'h0001);
    wr(2'd1, 16'hFFFE);
    burst(4, 3);                       // R3 wrap and carry
    check_eq("R3 carry into high half", 64'(xfer_ptr), 64'h0002_0002);

    // interrupts: pend bit0..3 = levels 1,2,4,6
    wr(2'd0, 16'h0400);
    pulse_drv();
    check_eq("R9 enabled drive irq sets level 6", 64'(irq_pend), 64'h8);
    wr(2'd0, 16'h0000);
    check_eq("R10 bit 10 fall clears level 6", 64'(irq_pend), 64'h0);
    pulse_drv();
    check_eq("R9 disabled drive irq ignored", 64'(irq_pend), 64'h0);
    @(negedge clk); ext_irq = 3'b111;
    @(negedge clk); ext_irq = 3'b000;
    check_eq("R11 sources set levels 1 2 4", 64'(irq_pend), 64'h7);
    wr(2'd0, 16'h0780);
    check_eq("R10 rising bits clear nothing", 64'(irq_pend), 64'h7);
    pulse_drv();
    check_eq("R9 drive irq with bit 10", 64'(irq_pend), 64'hF);
    wr(2'd0, 16'h0000);
    check_eq("R10 lowest falling bit only", 64'(irq_pend), 64'hE);
    wr(2'd0, 16'h0000);
    check_eq("R10 no falling bit no clear", 64'(irq_pend), 64'hE);
    wr(2'd0, 16'h0280);
    wr(2'd0, 16'h0000);
    check_eq("R10 bit 9 not acted when bit 7 falls", 64'(irq_pend), 64'hE);
    wr(2'd0, 16'h0200);
    wr(2'd0, 16'h0000);
    check_eq("R10 bit 9 clears level 4", 64'(irq_pend), 64'hA);
    wr(2'd0, 16'h0500);
    wr(2'd0, 16'h0400);
    check_eq("R10 bit 8 clears level 2", 64'(irq_pend), 64'h8);
    wr(2'd0, 16'h0000);
    check_eq("R10 bit 10 clears level 6", 64'(irq_pend), 64'h0);

    repeat (3) @(negedge clk);
    check_eq("R6 all expected words written", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule